// File: doc/BRIEF.md
# Multi-Mode Synchronous Serial Transmitter

This block turns bytes written by a host into a continuous serial bit stream for a synchronous link. Bytes enter through a valid/ready write port into a four-entry queue. A shift path sends one bit, least significant first, on every clock cycle where the bit-rate enable is high. The line never goes idle. In the character-oriented modes the engine sends a programmed sync pattern whenever the queue is empty. In the framed mode it sends flag characters between frames.

The framed mode wraps each run of data bytes between flags. The frame body is protected by a 16-bit frame check sequence. A zero is inserted after every five consecutive ones in the body and in the check sequence, so that the body can never look like a flag. The host marks the final byte of a frame with a strobe that travels alongside that byte. An optional NRZI coder sits at the output.

The write port follows these rules for back-pressure. A byte is taken on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly while the queue holds four bytes. A byte offered while `wr_ready` is low is dropped; it is not held for a later cycle.

Top module: `sync_tx_engine`

## Requirements
- R1: The queue holds up to 4 bytes, which are sent in the order written. `fifo_full` is high and `wr_ready` is low while it holds 4. A write offered while full is discarded and never appears on the line.
- R2: The line advances only on cycles where `bit_en` is high, one bit per such cycle. `txd` is registered: it shows that bit from the next clock edge and holds steady while `bit_en` is low. Bytes go out least significant bit first.
- R3: With `mode_sel` = 0 (single 8-bit sync) and an empty queue, the engine sends the 8 bits of `sync_lo`.
- R4: With `mode_sel` = 1 (single 6-bit sync) and an empty queue, the engine sends `sync_lo[5:0]`, six bits per pattern.
- R5: With `mode_sel` = 2 (double sync) and an empty queue, the engine sends a 16-bit pattern: `sync_lo` first, then `sync_hi`.
- R6: With `mode_sel` = 3 (framed), the engine sends `sync_hi` as the flag (the host loads 0x7E) while no frame is active. The first unit after reset is a flag. A frame starts only after a complete flag, and it ends with the check sequence followed by a flag.
- R7: The check sequence is CRC-16 with polynomial 0x1021, preset to 0xFFFF. It is computed over the data bits in line order. Its complement is sent as bits 15..8 first, then bits 7..0, each byte least significant bit first.
- R8: In the framed mode, a 0 is inserted after any five consecutive 1s in the data and check bits, including a run that ends the check sequence. Flags are never stuffed.
- R9: `wr_last` marks a frame's final byte in the framed mode and is ignored in the other modes. If the queue runs empty inside a frame, the frame is closed as though its last byte had carried the mark.
- R10: With `nrzi_en` high, each 0 bit toggles `txd` and each 1 bit leaves it unchanged. With `nrzi_en` low, `txd` carries the bit directly.
- R11: After reset, `txd` is 1, the queue is empty and `wr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | 0 single 8-bit sync, 1 single 6-bit sync, 2 double sync, 3 framed |
| nrzi_en | input | 1 | Enable NRZI line coding |
| sync_lo | input | 8 | Low sync character |
| sync_hi | input | 8 | High sync character; the flag in the framed mode |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Queue can accept a byte |
| wr_data | input | 8 | Byte to send |
| wr_last | input | 1 | Byte ends the current frame |
| fifo_full | output | 1 | Queue holds four bytes |
| bit_en | input | 1 | Bit-rate enable; one line bit per high cycle |
| txd | output | 1 | Serial line output |

## Verification
Most internal faults show up on the line within one character time. A wrong bit counter or a wrong load choice shifts every later bit. A bad check register corrupts the 16 bits just before the closing flag. A miscounted run of ones adds or drops a bit, and all following bits then arrive one place off. The bench therefore decodes the line back into bits and compares whole streams against sequences built from the requirements, so a single slipped bit is reported at the position where it first occurs. Queue faults show on `wr_ready` and `fifo_full` right after the writes, or as a lost or repeated byte in the stream.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [1:0] {
    MODE_MONO8  = 2'd0,
    MODE_MONO6  = 2'd1,
    MODE_BISYNC = 2'd2,
    MODE_FRAMED = 2'd3
  } stx_mode_e;

  typedef enum logic [1:0] {
    UNIT_SYNC = 2'd0,
    UNIT_DATA = 2'd1,
    UNIT_FCS  = 2'd2
  } unit_e;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_BODY = 2'd1,
    FR_FCS  = 2'd2
  } frame_e;

  localparam logic [15:0] FCS_POLY = 16'h1021;
  localparam int          RUN_MAX  = 5;
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/stx_crc_step.sv
module stx_crc_step #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic [W-1:0] crc_in,
  input  logic         bit_in,
  output logic [W-1:0] crc_out
);
  logic fb;
  assign fb      = crc_in[W-1] ^ bit_in;
  assign crc_out = {crc_in[W-2:0], 1'b0} ^ (fb ? POLY : '0);
endmodule

// File: rtl/stx_line_coder.sv
module stx_line_coder (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bit_in,
  input  logic nrzi_en,
  output logic line
);
  always_ff @(posedge clk) begin
    if (!rst_n)      line <= 1'b1;
    else if (bit_en) line <= nrzi_en ? (bit_in ? line : ~line) : bit_in;
  end
endmodule

// File: rtl/sync_tx_engine.sv
module sync_tx_engine
  import stx_pkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int CHAR_W  = 8,
  parameter int SHORT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              nrzi_en,
  input  logic [CHAR_W-1:0] sync_lo,
  input  logic [CHAR_W-1:0] sync_hi,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              fifo_full,
  input  logic              bit_en,
  output logic              txd
);
  localparam int SR_W  = 2 * CHAR_W;
  localparam int CNT_W = $clog2(SR_W + 1);
  localparam int QW    = CHAR_W + 1;
  localparam int FCW   = $clog2(DEPTH + 1);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  // queue
  logic [QW-1:0]  fifo_q;
  logic           fifo_empty, fifo_pop;
  logic [FCW-1:0] fifo_cnt;

  stx_fifo #(.W(QW), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (wr_valid),
    .wdata ({wr_last, wr_data}),
    .pop   (fifo_pop),
    .rdata (fifo_q),
    .empty (fifo_empty),
    .full  (fifo_full),
    .count (fifo_cnt)
  );
  assign wr_ready = !fifo_full;

  // shift state
  logic [SR_W-1:0]  sr;
  logic [CNT_W-1:0] cnt;
  unit_e            kind;
  logic [RUN_W-1:0] ones;
  frame_e           fstate;
  logic             after_flag;
  logic [SR_W-1:0]  crc;

  stx_mode_e mode;
  logic      framed;
  assign mode   = stx_mode_e'(mode_sel);
  assign framed = (mode == MODE_FRAMED);

  // next-unit selection
  logic [SR_W-1:0]  ld_sr;
  logic [CNT_W-1:0] ld_cnt;
  unit_e            ld_kind;
  frame_e           ld_state;
  logic             ld_flag, ld_pop, ld_crc_start;
  logic [SR_W-1:0]  fcs_word;

  assign fcs_word = {~crc[CHAR_W-1:0], ~crc[SR_W-1:CHAR_W]};

  always_comb begin
    ld_sr        = '0;
    ld_cnt       = '0;
    ld_kind      = UNIT_SYNC;
    ld_state     = fstate;
    ld_flag      = 1'b0;
    ld_pop       = 1'b0;
    ld_crc_start = 1'b0;
    if (framed) begin
      unique case (fstate)
        FR_IDLE: begin
          if (after_flag && !fifo_empty) begin
            ld_sr        = SR_W'(fifo_q[CHAR_W-1:0]);
            ld_cnt       = CNT_W'(CHAR_W);
            ld_kind      = UNIT_DATA;
            ld_pop       = 1'b1;
            ld_crc_start = 1'b1;
            ld_state     = fifo_q[CHAR_W] ? FR_FCS : FR_BODY;
          end else begin
            ld_sr   = SR_W'(sync_hi);
            ld_cnt  = CNT_W'(CHAR_W);
            ld_flag = 1'b1;
          end
        end
        FR_BODY: begin
          if (!fifo_empty) begin
            ld_sr    = SR_W'(fifo_q[CHAR_W-1:0]);
            ld_cnt   = CNT_W'(CHAR_W);
            ld_kind  = UNIT_DATA;
            ld_pop   = 1'b1;
            ld_state = fifo_q[CHAR_W] ? FR_FCS : FR_BODY;
          end else begin
            ld_sr    = fcs_word;
            ld_cnt   = CNT_W'(SR_W);
            ld_kind  = UNIT_FCS;
            ld_state = FR_IDLE;
          end
        end
        default: begin
          ld_sr    = fcs_word;
          ld_cnt   = CNT_W'(SR_W);
          ld_kind  = UNIT_FCS;
          ld_state = FR_IDLE;
        end
      endcase
    end else if (!fifo_empty) begin
      ld_sr   = SR_W'(fifo_q[CHAR_W-1:0]);
      ld_cnt  = CNT_W'(CHAR_W);
      ld_kind = UNIT_DATA;
      ld_pop  = 1'b1;
    end else begin
      unique case (mode)
        MODE_MONO6: begin
          ld_sr  = SR_W'(sync_lo[SHORT_W-1:0]);
          ld_cnt = CNT_W'(SHORT_W);
        end
        MODE_BISYNC: begin
          ld_sr  = {sync_hi, sync_lo};
          ld_cnt = CNT_W'(SR_W);
        end
        default: begin
          ld_sr  = SR_W'(sync_lo);
          ld_cnt = CNT_W'(CHAR_W);
        end
      endcase
    end
  end

  // current bit view
  logic             stuff_now, load;
  logic [SR_W-1:0]  cur_sr;
  logic [CNT_W-1:0] cur_cnt;
  unit_e            cur_kind;
  logic             tx_bit, stuffable;
  logic [SR_W-1:0]  crc_base, crc_step, crc_next;

  assign stuff_now = framed && (ones == RUN_W'(RUN_MAX));
  assign load      = !stuff_now && (cnt == '0);
  assign cur_sr    = load ? ld_sr   : sr;
  assign cur_cnt   = load ? ld_cnt  : cnt;
  assign cur_kind  = load ? ld_kind : kind;
  assign tx_bit    = stuff_now ? 1'b0 : cur_sr[0];
  assign stuffable = framed && (cur_kind != UNIT_SYNC);
  assign fifo_pop  = bit_en && load && ld_pop;
  assign crc_base  = (load && ld_crc_start) ? '1 : crc;

  stx_crc_step #(.W(SR_W), .POLY(FCS_POLY)) u_crc (
    .crc_in  (crc_base),
    .bit_in  (cur_sr[0]),
    .crc_out (crc_step)
  );
  assign crc_next = (framed && cur_kind == UNIT_DATA) ? crc_step : crc_base;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr         <= '0;
      cnt        <= '0;
      kind       <= UNIT_SYNC;
      ones       <= '0;
      fstate     <= FR_IDLE;
      after_flag <= 1'b0;
      crc        <= '1;
    end else if (bit_en) begin
      if (stuff_now) begin
        ones <= '0;
      end else begin
        sr   <= cur_sr >> 1;
        cnt  <= cur_cnt - 1'b1;
        kind <= cur_kind;
        ones <= (stuffable && cur_sr[0]) ? ones + 1'b1 : '0;
        crc  <= crc_next;
        if (load) begin
          fstate     <= ld_state;
          after_flag <= ld_flag;
        end
      end
    end
  end

  stx_line_coder u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .bit_in  (tx_bit),
    .nrzi_en (nrzi_en),
    .line    (txd)
  );
endmodule

// File: rtl/stx_checks.sv
module stx_checks #(
  parameter int DEPTH = 4,
  localparam int FCW  = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_en,
  input logic           nrzi_en,
  input logic           txd,
  input logic           tx_bit,
  input logic [2:0]     ones,
  input logic [FCW-1:0] fifo_cnt,
  input logic           fifo_pop,
  input logic           fifo_empty
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= FCW'(DEPTH)); // R1
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd)); // R2
  AST_PLAIN_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && !nrzi_en |=> txd == $past(tx_bit)); // R2
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= 3'd5); // R8
  AST_NRZI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && nrzi_en && !tx_bit |=> txd != $past(txd)); // R10
  AST_NRZI_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && nrzi_en && tx_bit |=> $stable(txd)); // R10
endmodule

bind sync_tx_engine stx_checks #(.DEPTH(DEPTH)) u_checks (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_en     (bit_en),
  .nrzi_en    (nrzi_en),
  .txd        (txd),
  .tx_bit     (tx_bit),
  .ones       (ones),
  .fifo_cnt   (fifo_cnt),
  .fifo_pop   (fifo_pop),
  .fifo_empty (fifo_empty)
);

// File: tb/tb_sync_tx_engine.sv
module tb_sync_tx_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       nrzi_en = 1'b0;
  logic [7:0] sync_lo = 8'h00, sync_hi = 8'h7E;
  logic       wr_valid = 1'b0, wr_last = 1'b0, bit_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, fifo_full, txd;

  always #4 clk = ~clk;

  sync_tx_engine dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .nrzi_en(nrzi_en),
    .sync_lo(sync_lo), .sync_hi(sync_hi), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .wr_last(wr_last),
    .fifo_full(fifo_full), .bit_en(bit_en), .txd(txd)
  );

  int   n_chk = 0, n_bad = 0, hold_err = 0, st_ones = 0;
  bit   done = 0;
  logic [7:0] bq[$];
  bit   exp_q[$], got_q[$];

  task automatic check(input bit ok, input string tag, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic void exp_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v[i]);
  endfunction

  function automatic void stuff_push(input bit b);
    exp_q.push_back(b);
    st_ones = b ? st_ones + 1 : 0;
    if (st_ones == 5) begin
      exp_q.push_back(1'b0);
      st_ones = 0;
    end
  endfunction

  function automatic logic [15:0] crc_bit(input logic [15:0] c, input bit b);
    logic fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

  // R6 R7 R8: opening flag, stuffed body and check sequence, closing flag, idle flag
  function automatic void exp_frame();
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    exp_bits(16'h007E, 8);
    st_ones = 0;
    foreach (bq[k])
      for (int i = 0; i < 8; i++) begin
        stuff_push(bq[k][i]);
        c = crc_bit(c, bq[k][i]);
      end
    fcs = ~c;
    for (int i = 8; i < 16; i++) stuff_push(fcs[i]);
    for (int i = 0; i < 8; i++) stuff_push(fcs[i]);
    exp_bits(16'h007E, 8);
    exp_bits(16'h007E, 8);
  endfunction

  task automatic do_reset(input logic [1:0] m, input bit nz);
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; wr_valid = 1'b0;
    mode_sel = m; nrzi_en = nz;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_byte(input logic [7:0] b, input bit last);
    wr_valid = 1'b1; wr_data = b; wr_last = last;
    @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic capture(input int n, input int density);
    bit en_prev = 0;
    logic prev_line = 1'b1;
    logic last_txd = txd;
    int guard = 0;
    got_q.delete();
    while (got_q.size() < n && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (en_prev) begin
        if (nrzi_en) begin
          got_q.push_back(txd == prev_line);
          prev_line = txd;
        end else got_q.push_back(txd);
      end else if (txd !== last_txd) hold_err++;
      last_txd = txd;
      bit_en = ($urandom_range(99) < density);
      en_prev = bit_en;
    end
    bit_en = 1'b0;
  endtask

  task automatic compare(input string tag);
    int mis = -1;
    for (int i = 0; i < exp_q.size(); i++)
      if (mis < 0 && (i >= got_q.size() || got_q[i] != exp_q[i])) mis = i;
    if (mis >= 0)
      check(0, {tag, " bit index"}, mis < got_q.size() ? int'(got_q[mis]) : -1,
            int'(exp_q[mis]));
    else check(1, tag, 0, 0);
  endtask

  // One scenario: reset, preload bytes with the line stalled, then stream.
  task automatic scenario(input string tag, input logic [1:0] m, input bit nz,
                          input int density, input bit mark_last, input int extra);
    int nb;
    do_reset(m, nz);
    foreach (bq[k]) push_byte(bq[k], mark_last && (k == bq.size() - 1));
    if (bq.size() >= 4) check(fifo_full && !wr_ready, {tag, " R1 full"}, fifo_full, 1);
    else check(!fifo_full && wr_ready, {tag, " R1 not full"}, fifo_full, 0);
    exp_q.delete();
    if (m == 2'd3) begin
      if (bq.size() == 0) for (int i = 0; i < extra; i++) exp_bits(16'h007E, 8);
      else exp_frame();
    end else begin
      nb = (bq.size() > 4) ? 4 : bq.size();
      for (int k = 0; k < nb; k++) exp_bits({8'h00, bq[k]}, 8);
      for (int i = 0; i < extra; i++)
        case (m)
          2'd1:    exp_bits({8'h00, sync_lo}, 6);
          2'd2:    exp_bits({sync_hi, sync_lo}, 16);
          default: exp_bits({8'h00, sync_lo}, 8);
        endcase
    end
    capture(exp_q.size(), density);
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R11 reset state
    do_reset(2'd0, 1'b0);
    check(txd === 1'b1, "R11 txd idle", txd, 1);
    check(wr_ready === 1'b1 && fifo_full === 1'b0, "R11 queue empty", fifo_full, 0);

    // R1 R3: overflow write dropped, then single 8-bit syncs
    sync_lo = 8'hA6; sync_hi = 8'h3C;
    bq = '{8'h11, 8'h82, 8'hF0, 8'h5A, 8'hEE};
    scenario("R1 R3 mono8 overflow", 2'd0, 1'b0, 60, 1'b0, 2);

    // R4 R9: 6-bit syncs, last mark ignored
    sync_lo = 8'hD9;
    bq = '{8'h0F, 8'hC3};
    scenario("R4 R9 mono6", 2'd1, 1'b0, 100, 1'b1, 3);

    // R5: 16-bit double sync
    sync_lo = 8'h16; sync_hi = 8'h97;
    bq = '{8'h44};
    scenario("R5 bisync", 2'd2, 1'b0, 45, 1'b0, 2);

    // R6: idle flags only
    sync_hi = 8'h7E;
    bq.delete();
    scenario("R6 idle flags", 2'd3, 1'b0, 100, 1'b0, 4);

    // R7 R8: long runs of ones force stuffing
    bq = '{8'hFF, 8'hFF};
    scenario("R7 R8 stuffed frame", 2'd3, 1'b0, 100, 1'b1, 0);
    bq = '{8'h1F};
    scenario("R7 single byte", 2'd3, 1'b0, 70, 1'b1, 0);

    // R10: NRZI coded frame
    bq = '{8'h7E, 8'hF8, 8'h1F};
    scenario("R10 nrzi frame", 2'd3, 1'b1, 80, 1'b1, 0);

    // R9: queue runs dry mid-frame without a mark
    bq = '{8'hA5, 8'h3E};
    scenario("R9 underrun close", 2'd3, 1'b0, 100, 1'b0, 0);

    // random mix
    for (int it = 0; it < 8; it++) begin
      int nb = $urandom_range(1, 4);
      logic [1:0] m = (it % 2 == 0) ? 2'd3 : 2'($urandom_range(0, 2));
      bq.delete();
      for (int k = 0; k < nb; k++) bq.push_back(($urandom_range(3) == 0) ? 8'hFF : 8'($urandom));
      sync_lo = 8'($urandom);
      sync_hi = (m == 2'd3) ? 8'h7E : 8'($urandom);
      scenario("R2 R6 R8 random", m, 1'($urandom), $urandom_range(30, 100), 1'b1, 2);
    end

    // R2: line held on every stalled cycle seen
    check(hold_err == 0, "R2 hold while stalled", hold_err, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule